// File: doc/BRIEF.md
# Shadowed Converter Control Register Bank

This block keeps the control settings of a data converter behind a simple parallel host port. The port has an address, write data, write and read strobes, and registered read data. Every writable setting is held twice. The host writes a master copy. A slave copy drives the converter logic. The slave copies change only when the host issues a transfer command, and that command updates all of them on the same clock edge. A group of settings can therefore be staged one register at a time and applied together.

The bank also contains a port-configuration byte, read-only identification bytes and a soft-reset path. The port-configuration byte takes effect as soon as it is written. Its bit-order flag and its soft-reset flag each appear in both nibbles, so the byte means the same thing whichever bit order delivered it. A soft reset returns every setting to its default and does not remain set. The block only stores and decodes settings. What each setting does inside the converter is outside its scope.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After the synchronous reset, address 0x00 reads 0x18, address 0x09 reads 0x01, and every other writable address and 0xFF read 0x00. The outputs show stabilizer enabled, power mode 00, divide ratio 1, and zero on all other fields.
- R2: A write to a writable address (0x08, 0x09, 0x0B, 0x0D, 0x0E, 0x10) changes what that address reads back. It does not change any slave output until a transfer.
- R3: A write to 0xFF with bit 0 = 1 copies all six master registers into their slaves on that edge, so every output changes together in the next cycle. A write to 0xFF with bit 0 = 0 copies nothing.
- R4: The transfer flag clears itself in the cycle after the copy, so a later read of 0xFF returns 0x00.
- R5: Writing address 0x00 with bit 6 or bit 1 set makes the bit-order output 1 at once; writing both clear makes it 0. Address 0x00 reads 0x5A when the flag is set and 0x18 when it is clear.
- R6: Writing address 0x00 with bit 5 or bit 2 set returns all masters, all slaves and the bit-order flag to their reset values in the next cycle. Those two bits always read back as 0.
- R7: Address 0x01 reads the chip ID (default 0x78). Address 0x02 reads the speed-grade code in bits 6:4 (default 011, giving 0x30) with all other bits 0. Writes to both addresses are ignored.
- R8: Any address outside the implemented set reads 0x00. A write to such an address changes no register and no output.
- R9: Field mapping, applied on transfer:
  - 0x08: bits 1:0 are the power mode, bit 7 enables the external pin, and bits 6:5 choose what the pin does. Its other bits are stored as 0.
  - 0x09: bit 0 enables the stabilizer.
  - 0x0B: bits 2:0 give a divide ratio equal to that value plus 1.
  - 0x0D: all eight bits are the test control.
  - 0x0E: only bits 2 and 0 are stored.
  - 0x10: the whole byte is a two's-complement offset.
- R10: Read data appears on the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_rdata | output | 8 | Registered read data |
| lsb_first | output | 1 | Bit-order flag from the port-configuration byte |
| pwr_mode | output | 2 | Power mode (00 run, 01 power-down, 10 standby, 11 digital reset) |
| ext_pin_en | output | 1 | External pin function enable |
| ext_pin_func | output | 2 | External pin function select |
| dcs_en | output | 1 | Duty-cycle stabilizer enable |
| clk_div_ratio | output | 4 | Clock divide ratio, 1 to 8 |
| test_ctrl | output | 8 | Output test control byte |
| selftest_ctrl | output | 8 | Self-test control byte |
| offset_trim | output | 8 | Signed offset trim |

## Verification
The main function is staging followed by a transfer. It is driven with several distinct stagings:
- The same registers are loaded with the most negative offset and the largest divide code, then with the most positive offset and a different power and pin mix. This shows that every field is routed to its own output.
- Writes that set bits outside a register's mask show which bits are really stored.
- A write to 0xFF with bit 0 clear checks that only bit 0 starts a copy.
- The mirrored port flag is set from each nibble in turn, which separates a design that decodes both nibbles from one that decodes only one.
- Soft reset is started from each of its two bit positions after state has been disturbed. Unmapped writes are checked for aliasing onto live registers.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
  localparam int DATA_W = 8;
  localparam int NREG   = 6;

  // Index of each shadowed register in the bank
  localparam int IDX_MODE   = 0;
  localparam int IDX_CLKCFG = 1;
  localparam int IDX_DIV    = 2;
  localparam int IDX_TEST   = 3;
  localparam int IDX_SELF   = 4;
  localparam int IDX_OFFS   = 5;

  localparam logic [7:0] A_PORTCFG = 8'h00;
  localparam logic [7:0] A_CHIPID  = 8'h01;
  localparam logic [7:0] A_GRADE   = 8'h02;
  localparam logic [7:0] A_XFER    = 8'hFF;

  function automatic logic [7:0] reg_addr(input int i);
    case (i)
      IDX_MODE:   reg_addr = 8'h08;
      IDX_CLKCFG: reg_addr = 8'h09;
      IDX_DIV:    reg_addr = 8'h0B;
      IDX_TEST:   reg_addr = 8'h0D;
      IDX_SELF:   reg_addr = 8'h0E;
      default:    reg_addr = 8'h10;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_rst(input int i);
    reg_rst = (i == IDX_CLKCFG) ? 8'h01 : 8'h00;
  endfunction

  // Bits that are actually stored in each register
  function automatic logic [DATA_W-1:0] reg_mask(input int i);
    case (i)
      IDX_MODE:   reg_mask = 8'hE3;
      IDX_CLKCFG: reg_mask = 8'h01;
      IDX_DIV:    reg_mask = 8'h07;
      IDX_TEST:   reg_mask = 8'hFF;
      IDX_SELF:   reg_mask = 8'h05;
      default:    reg_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_shadow_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit_reg,
  output logic              hit_port,
  output logic              hit_id,
  output logic              hit_grade,
  output logic              hit_xfer
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit_reg[i] = (addr == ADDR_W'(reg_addr(i)));
  end

  assign hit_port  = (addr == ADDR_W'(A_PORTCFG));
  assign hit_id    = (addr == ADDR_W'(A_CHIPID));
  assign hit_grade = (addr == ADDR_W'(A_GRADE));
  assign hit_xfer  = (addr == ADDR_W'(A_XFER));
endmodule

// File: rtl/cfg_shadow_pair.sv
module cfg_shadow_pair #(
  parameter int         W    = 8,
  parameter logic [W-1:0] RST  = '0,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         xfer,
  output logic [W-1:0] master,
  output logic [W-1:0] slave
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      master <= RST;
      slave  <= RST;
    end else begin
      if (wr_en) master <= wdata & MASK;
      if (xfer)  slave  <= master;
    end
  end
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
  import cfg_shadow_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] CHIP_ID    = 8'h78,
  parameter logic [2:0] SPEED_CODE = 3'b011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [7:0]        host_rdata,
  output logic              lsb_first,
  output logic [1:0]        pwr_mode,
  output logic              ext_pin_en,
  output logic [1:0]        ext_pin_func,
  output logic              dcs_en,
  output logic [3:0]        clk_div_ratio,
  output logic [7:0]        test_ctrl,
  output logic [7:0]        selftest_ctrl,
  output logic [7:0]        offset_trim
);
  logic [NREG-1:0]   hit_reg;
  logic              hit_port, hit_id, hit_grade, hit_xfer;
  logic              soft_rst, xfer, xfer_q, lsb_q;
  logic [DATA_W-1:0] mst [NREG];
  logic [DATA_W-1:0] slv [NREG];
  logic [DATA_W-1:0] rd_val;

  cfg_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr      (host_addr),
    .hit_reg   (hit_reg),
    .hit_port  (hit_port),
    .hit_id    (hit_id),
    .hit_grade (hit_grade),
    .hit_xfer  (hit_xfer)
  );

  // Either nibble's copy of the soft-reset flag triggers it
  assign soft_rst = host_wr && hit_port && (host_wdata[5] || host_wdata[2]);
  assign xfer     = host_wr && hit_xfer && host_wdata[0];

  for (genvar i = 0; i < NREG; i++) begin : g_pair
    cfg_shadow_pair #(
      .W    (DATA_W),
      .RST  (reg_rst(i)),
      .MASK (reg_mask(i))
    ) u_pair (
      .clk    (clk),
      .rst    (rst),
      .clr    (soft_rst),
      .wr_en  (host_wr && hit_reg[i]),
      .wdata  (host_wdata),
      .xfer   (xfer),
      .master (mst[i]),
      .slave  (slv[i])
    );
  end

  // Port configuration acts immediately; the bit-order flag is mirrored
  always_ff @(posedge clk) begin
    if (rst || soft_rst)        lsb_q <= 1'b0;
    else if (host_wr && hit_port) lsb_q <= host_wdata[6] || host_wdata[1];
  end

  // Transfer flag: set on the copy edge, gone one cycle later
  always_ff @(posedge clk) begin
    if (rst || soft_rst) xfer_q <= 1'b0;
    else                 xfer_q <= xfer;
  end

  always_comb begin
    rd_val = '0;
    if (hit_port)  rd_val = {1'b0, lsb_q, 1'b0, 1'b1, 1'b1, 1'b0, lsb_q, 1'b0};
    if (hit_id)    rd_val = CHIP_ID;
    if (hit_grade) rd_val = {1'b0, SPEED_CODE, 4'b0000};
    if (hit_xfer)  rd_val = {7'b0, xfer_q};
    for (int i = 0; i < NREG; i++)
      if (hit_reg[i]) rd_val = mst[i];
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_val;
  end

  assign lsb_first     = lsb_q;
  assign pwr_mode      = slv[IDX_MODE][1:0];
  assign ext_pin_en    = slv[IDX_MODE][7];
  assign ext_pin_func  = slv[IDX_MODE][6:5];
  assign dcs_en        = slv[IDX_CLKCFG][0];
  assign clk_div_ratio = {1'b0, slv[IDX_DIV][2:0]} + 4'd1;
  assign test_ctrl     = slv[IDX_TEST];
  assign selftest_ctrl = slv[IDX_SELF];
  assign offset_trim   = slv[IDX_OFFS];
endmodule

// File: rtl/cfg_shadow_checker.sv
module cfg_shadow_checker #(
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] CHIP_ID = 8'h78
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic              host_wr,
  input logic              host_rd,
  input logic [7:0]        host_rdata,
  input logic              lsb_first,
  input logic [1:0]        pwr_mode,
  input logic              ext_pin_en,
  input logic [1:0]        ext_pin_func,
  input logic              dcs_en,
  input logic [3:0]        clk_div_ratio,
  input logic [7:0]        test_ctrl,
  input logic [7:0]        selftest_ctrl,
  input logic [7:0]        offset_trim
);
  logic soft_cmd, copy_cmd, unmapped;
  logic [23:0] outs;

  assign soft_cmd = host_wr && host_addr == ADDR_W'(8'h00)
                    && (host_wdata[5] || host_wdata[2]);
  assign copy_cmd = host_wr && host_addr == ADDR_W'(8'hFF) && host_wdata[0];
  assign unmapped = !(host_addr == ADDR_W'(8'h00) || host_addr == ADDR_W'(8'h01) ||
                      host_addr == ADDR_W'(8'h02) || host_addr == ADDR_W'(8'h08) ||
                      host_addr == ADDR_W'(8'h09) || host_addr == ADDR_W'(8'h0B) ||
                      host_addr == ADDR_W'(8'h0D) || host_addr == ADDR_W'(8'h0E) ||
                      host_addr == ADDR_W'(8'h10) || host_addr == ADDR_W'(8'hFF));
  assign outs = {pwr_mode, ext_pin_en, ext_pin_func, dcs_en, clk_div_ratio[2:0],
                 test_ctrl[0], selftest_ctrl, offset_trim};

  // R1
  p_reset_defaults_r1: assert property (@(posedge clk)
    rst |=> (dcs_en && pwr_mode == 2'b00 && offset_trim == 8'h00 && !lsb_first
             && clk_div_ratio == 4'd1 && host_rdata == 8'h00));

  // R2 / R3: slaves move only on a transfer or a soft reset
  p_hold_without_xfer_r2: assert property (@(posedge clk) disable iff (rst)
    (!copy_cmd && !soft_cmd) |=> ($stable(outs) && $stable(test_ctrl)));

  // R4
  p_xfer_selfclear_r4: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == ADDR_W'(8'hFF) && !$past(host_wr)) |=> host_rdata == 8'h00);

  // R6
  p_soft_reset_r6: assert property (@(posedge clk) disable iff (rst)
    soft_cmd |=> (!lsb_first && dcs_en && pwr_mode == 2'b00 && offset_trim == 8'h00
                  && test_ctrl == 8'h00 && clk_div_ratio == 4'd1));

  // R7
  p_chip_id_r7: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == ADDR_W'(8'h01)) |=> host_rdata == CHIP_ID);

  // R8
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (host_rd && unmapped) |=> host_rdata == 8'h00);

  // R9
  p_ratio_range_r9: assert property (@(posedge clk) disable iff (rst)
    (clk_div_ratio >= 4'd1 && clk_div_ratio <= 4'd8));

  // R10
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
endmodule

bind cfg_shadow_bank cfg_shadow_checker #(.ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .host_addr     (host_addr),
  .host_wdata    (host_wdata),
  .host_wr       (host_wr),
  .host_rd       (host_rd),
  .host_rdata    (host_rdata),
  .lsb_first     (lsb_first),
  .pwr_mode      (pwr_mode),
  .ext_pin_en    (ext_pin_en),
  .ext_pin_func  (ext_pin_func),
  .dcs_en        (dcs_en),
  .clk_div_ratio (clk_div_ratio),
  .test_ctrl     (test_ctrl),
  .selftest_ctrl (selftest_ctrl),
  .offset_trim   (offset_trim)
);

// File: tb/cfg_shadow_bank_bench.sv
`timescale 1ns/1ps
module cfg_shadow_bank_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] host_addr, host_wdata, host_rdata;
  logic       host_wr, host_rd;
  logic       lsb_first, ext_pin_en, dcs_en;
  logic [1:0] pwr_mode, ext_pin_func;
  logic [3:0] clk_div_ratio;
  logic [7:0] test_ctrl, selftest_ctrl, offset_trim;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_shadow_bank u_cfg_shadow_bank (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .lsb_first(lsb_first), .pwr_mode(pwr_mode), .ext_pin_en(ext_pin_en),
    .ext_pin_func(ext_pin_func), .dcs_en(dcs_en), .clk_div_ratio(clk_div_ratio),
    .test_ctrl(test_ctrl), .selftest_ctrl(selftest_ctrl), .offset_trim(offset_trim)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset;
    rd_check("R1 portcfg", 8'h00, 8'h18);
    rd_check("R1 mode",    8'h08, 8'h00);
    rd_check("R1 clkcfg",  8'h09, 8'h01);
    rd_check("R1 div",     8'h0B, 8'h00);
    rd_check("R1 test",    8'h0D, 8'h00);
    rd_check("R1 self",    8'h0E, 8'h00);
    rd_check("R1 offset",  8'h10, 8'h00);
    rd_check("R1 xfer",    8'hFF, 8'h00);
    check("R1 dcs_en", {7'b0, dcs_en}, 8'h01);
    check("R1 ratio", {4'b0, clk_div_ratio}, 8'h01);
    check("R1 lsb_first", {7'b0, lsb_first}, 8'h00);
  endtask

  task automatic t_stage;
    wr(8'h10, 8'h80); wr(8'h0B, 8'hFF); wr(8'h08, 8'hFF);
    wr(8'h09, 8'h00); wr(8'h0D, 8'hA5); wr(8'h0E, 8'hFF);
    rd_check("R2 offset master", 8'h10, 8'h80);
    rd_check("R9 div mask",      8'h0B, 8'h07);
    rd_check("R9 mode mask",     8'h08, 8'hE3);
    rd_check("R2 clkcfg master", 8'h09, 8'h00);
    rd_check("R9 self mask",     8'h0E, 8'h05);
    check("R2 offset out held", offset_trim, 8'h00);
    check("R2 dcs out held", {7'b0, dcs_en}, 8'h01);
    check("R2 test out held", test_ctrl, 8'h00);
  endtask

  task automatic t_xfer_bit_clear;
    wr(8'hFF, 8'hFE);
    check("R3 no copy offset", offset_trim, 8'h00);
    check("R3 no copy ratio", {4'b0, clk_div_ratio}, 8'h01);
  endtask

  task automatic t_xfer;
    wr(8'hFF, 8'h01);
    check("R3 offset", offset_trim, 8'h80);
    check("R9 ratio max", {4'b0, clk_div_ratio}, 8'h08);
    check("R9 pwr", {6'b0, pwr_mode}, 8'h03);
    check("R9 pin_en", {7'b0, ext_pin_en}, 8'h01);
    check("R9 pin_func", {6'b0, ext_pin_func}, 8'h03);
    check("R3 dcs", {7'b0, dcs_en}, 8'h00);
    check("R3 test", test_ctrl, 8'hA5);
    check("R3 self", selftest_ctrl, 8'h05);
    rd_check("R4 xfer reads zero", 8'hFF, 8'h00);
    wr(8'h10, 8'h7F); wr(8'h08, 8'h41); wr(8'h0B, 8'h02);
    check("R2 second stage held", offset_trim, 8'h80);
    wr(8'hFF, 8'h01);
    check("R3 offset max", offset_trim, 8'h7F);
    check("R9 pwr 01", {6'b0, pwr_mode}, 8'h01);
    check("R9 pin_func 10", {6'b0, ext_pin_func}, 8'h02);
    check("R9 pin_en off", {7'b0, ext_pin_en}, 8'h00);
    check("R9 ratio 3", {4'b0, clk_div_ratio}, 8'h03);
  endtask

  task automatic t_mirror;
    wr(8'h00, 8'h40);
    check("R5 upper nibble", {7'b0, lsb_first}, 8'h01);
    rd_check("R5 read set", 8'h00, 8'h5A);
    wr(8'h00, 8'h00);
    check("R5 cleared", {7'b0, lsb_first}, 8'h00);
    rd_check("R5 read clear", 8'h00, 8'h18);
    wr(8'h00, 8'h02);
    check("R5 lower nibble", {7'b0, lsb_first}, 8'h01);
  endtask

  task automatic t_soft(input logic [7:0] cmd);
    wr(8'h00, 8'h42);
    wr(8'h10, 8'h33); wr(8'h09, 8'h00); wr(8'hFF, 8'h01);
    check("R6 setup", offset_trim, 8'h33);
    wr(8'h00, cmd);
    check("R6 offset", offset_trim, 8'h00);
    check("R6 dcs", {7'b0, dcs_en}, 8'h01);
    check("R6 lsb", {7'b0, lsb_first}, 8'h00);
    check("R6 ratio", {4'b0, clk_div_ratio}, 8'h01);
    rd_check("R6 portcfg", 8'h00, 8'h18);
    rd_check("R6 offset master", 8'h10, 8'h00);
    rd_check("R6 clkcfg master", 8'h09, 8'h01);
  endtask

  task automatic t_ids;
    rd_check("R7 chip id", 8'h01, 8'h78);
    rd_check("R7 grade", 8'h02, 8'h30);
    wr(8'h01, 8'h00); wr(8'h02, 8'hFF);
    rd_check("R7 id after write", 8'h01, 8'h78);
    rd_check("R7 grade after write", 8'h02, 8'h30);
  endtask

  task automatic t_unmapped;
    wr(8'h10, 8'h5C); wr(8'hFF, 8'h01);
    wr(8'h05, 8'hFF); wr(8'h0A, 8'hFF); wr(8'h11, 8'hFF); wr(8'h90, 8'hFF);
    rd_check("R8 0x05", 8'h05, 8'h00);
    rd_check("R8 0x0A", 8'h0A, 8'h00);
    rd_check("R8 0x90", 8'h90, 8'h00);
    rd_check("R8 offset intact", 8'h10, 8'h5C);
    check("R8 outputs intact", offset_trim, 8'h5C);
  endtask

  task automatic t_rd_hold;
    logic [7:0] v;
    rd(8'h01, v);
    repeat (3) @(negedge clk);
    check("R10 rdata held", host_rdata, 8'h78);
  endtask

  initial begin
    rst = 1'b1; host_addr = '0; host_wdata = '0; host_wr = 1'b0; host_rd = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_stage;
    t_xfer_bit_clear;
    t_xfer;
    t_mirror;
    t_soft(8'h20);
    t_soft(8'h04);
    t_ids;
    t_unmapped;
    t_rd_hold;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500us;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule